// File: doc/BRIEF.md
# Paged Processor Register Port

This block is the slave side of an 8-bit, non-multiplexed processor bus for a time-slot switch. Six address lines, an active-low chip select, an active-high data strobe and a read/write line select either a single control register or one of 32 channel locations in a memory page. The control register picks which memory the page belongs to (data memory, connection-low or connection-high) and which serial stream the page covers. The low five address lines then pick the channel inside that page. A split mode sends reads to the data memory and writes to connection-low without reprogramming the page.

Memory accesses are not performed directly. The block raises a request toward the memories and waits until the TDM side offers an arbitration slot. After the grant it waits out the read latency of the target memory, which is longer for the data memory. Only then does it pull the active-low acknowledge. The acknowledge stays low until the strobe is withdrawn. The message-enable bit of the control register is exported so that the output path can apply it to every channel. Bus inputs are expected to be synchronous to `clk_i`.

Top module: `proc_reg_port`

## Requirements
- R1: After reset the control register reads 0x00, `ack_no` is high, `mem_req_o` is low and `msg_en_o` is low.
- R2: With `addr_i[5]`=0 the control register is accessed, and `rw_i`=1 means read. A write stores every bit except bit 5, which always reads 0. Bit 6 drives `msg_en_o`.
- R3: An access that uses no memory (the control register, a reserved page or a refused write) acknowledges CTRL_DLY+1 rising edges after the first edge that samples `cs_ni`=0 with `ds_i`=1. The default is the 3rd edge.
- R4: With `addr_i[5]`=1 a memory request is issued. `mem_sel_o` comes from control bits 4:3 (01 data, 10 connection-low, 11 connection-high). `mem_addr_o` = {control bits 2:0, `addr_i[4:0]`}. `mem_wdata_o` carries the written byte.
- R5: No write request to the data memory (select 01) is ever issued, and memory select 00 produces no request. Such accesses acknowledge with R3 timing, and a read of them returns 0x00.
- R6: While control bit 7 is set, every memory read targets the data memory and every memory write targets connection-low, whatever bits 4:3 hold. Bits 2:0 still choose the stream.
- R7: `mem_req_o` is held, with stable address, select and direction, until a cycle with `slot_i`=1. `ack_no` stays high while the request waits.
- R8: A write acknowledges on the edge after the grant edge. A read acknowledges CM_LAT edges after the grant for connection memories and DM_LAT edges after the grant for the data memory (1 and 3 by default). `rdata_o` holds `mem_rdata_i` sampled on the last of those edges.
- R9: `ack_no` stays low while `cs_ni`=0 and `ds_i`=1. It returns high after the first edge that samples the strobe released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ds_i | input | 1 | Data strobe, active high |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Bit 5 selects memory page vs control register; bits 4:0 channel |
| wdata_i | input | 8 | Write data from the processor |
| rdata_o | output | 8 | Read data, valid while `ack_no` is low |
| ack_no | output | 1 | Transfer acknowledge, active low |
| slot_i | input | 1 | Arbitration slot offered by the TDM side |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_sel_o | output | 2 | Target memory: 01 data, 10 connection-low, 11 connection-high |
| mem_addr_o | output | 8 | Stream and channel index |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read data returned by the selected memory |
| msg_en_o | output | 1 | Global message-enable from control bit 6 |

## Verification
The bench targets the paging arithmetic and the split mode. A design that swapped the stream and channel fields, or ignored split mode, would write bytes to the wrong location or the wrong memory, and those bytes would come back at the wrong place. It counts acknowledge edges for each kind of access. Giving the data memory the connection latency would return stale read data one or two edges early. It also withholds the arbitration slot for several cycles, and writes to the data memory and to the reserved page. A design that acknowledged before the grant, or let a refused write through, would be caught by its grant recorder. The acknowledge is also checked to hold while the strobe stays up and to release after the strobe falls.

// File: rtl/proc_port_pkg.sv
package proc_port_pkg;
  localparam int CTRL_W    = 8;
  localparam int SPLIT_BIT = 7;
  localparam int MSG_BIT   = 6;
  localparam int SPARE_BIT = 5;
  localparam int SEL_HI    = 4;
  localparam int SEL_LO    = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CLO  = 2'b10,
    SEL_CHI  = 2'b11
  } mem_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIX,
    ST_WAIT,
    ST_LAT,
    ST_ACK
  } seq_state_e;
endpackage

// File: rtl/proc_port_ctrl_reg.sv
module proc_port_ctrl_reg
  import proc_port_pkg::*;
#(
  parameter int ST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              split_o,
  output logic              msg_en_o,
  output mem_sel_e          sel_o,
  output logic [ST_W-1:0]   stream_o
);
  localparam logic [CTRL_W-1:0] KEEP_MASK = ~(CTRL_W'(1) << SPARE_BIT);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & KEEP_MASK;
  end

  assign ctrl_o   = ctrl_q;
  assign split_o  = ctrl_q[SPLIT_BIT];
  assign msg_en_o = ctrl_q[MSG_BIT];
  assign sel_o    = mem_sel_e'(ctrl_q[SEL_HI:SEL_LO]);
  assign stream_o = ctrl_q[ST_W-1:0];

  p_msg_en_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(msg_en_o));
  p_spare_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[SPARE_BIT] == 1'b0);
endmodule

// File: rtl/proc_port_decode.sv
module proc_port_decode
  import proc_port_pkg::*;
#(
  parameter int AW   = 6,
  parameter int CH_W = 5,
  parameter int ST_W = 3
) (
  input  logic [AW-1:0]        addr_i,
  input  logic                 rw_i,
  input  logic                 split_i,
  input  mem_sel_e             sel_i,
  input  logic [ST_W-1:0]      stream_i,
  output logic                 is_ctrl_o,
  output logic                 mem_ok_o,
  output mem_sel_e             sel_o,
  output logic [ST_W+CH_W-1:0] maddr_o
);
  mem_sel_e eff_sel;

  always_comb begin
    if (split_i) eff_sel = rw_i ? SEL_DATA : SEL_CLO;
    else         eff_sel = sel_i;
  end

  assign is_ctrl_o = ~addr_i[AW-1];
  assign sel_o     = eff_sel;
  assign mem_ok_o  = ~is_ctrl_o && (eff_sel != SEL_NONE) &&
                     !((eff_sel == SEL_DATA) && !rw_i);
  assign maddr_o   = {stream_i, addr_i[CH_W-1:0]};
endmodule

// File: rtl/proc_port_seq.sv
module proc_port_seq
  import proc_port_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MA_W     = 8,
  parameter int CTRL_DLY = 2,
  parameter int CM_LAT   = 1,
  parameter int DM_LAT   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic            rw_i,
  input  logic            is_ctrl_i,
  input  logic            mem_ok_i,
  input  mem_sel_e        sel_i,
  input  logic [MA_W-1:0] maddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   ctrl_q_i,
  input  logic            slot_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            ctrl_we_o,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output mem_sel_e        mem_sel_o,
  output logic [MA_W-1:0] mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o
);
  localparam int MAX_A = (CTRL_DLY > CM_LAT) ? CTRL_DLY : CM_LAT;
  localparam int MAX_L = (MAX_A > DM_LAT) ? MAX_A : DM_LAT;
  localparam int CNT_W = $clog2(MAX_L + 1);

  seq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]   rdata_q;
  logic            we_q;
  mem_sel_e        sel_q;
  logic [MA_W-1:0] addr_q;
  logic [DW-1:0]   wd_q;

  assign ctrl_we_o = (state_q == ST_IDLE) && strobe_i && is_ctrl_i && !rw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      sel_q   <= SEL_NONE;
      addr_q  <= '0;
      wd_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (strobe_i) begin
          if (is_ctrl_i) begin
            rdata_q <= ctrl_q_i;
            cnt_q   <= CNT_W'(CTRL_DLY - 1);
            state_q <= ST_FIX;
          end else if (mem_ok_i) begin
            we_q    <= ~rw_i;
            sel_q   <= sel_i;
            addr_q  <= maddr_i;
            wd_q    <= wdata_i;
            state_q <= ST_WAIT;
          end else begin
            rdata_q <= '0;
            cnt_q   <= CNT_W'(CTRL_DLY - 1);
            state_q <= ST_FIX;
          end
        end
        ST_FIX: begin
          if (cnt_q == '0) state_q <= ST_ACK;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_WAIT: if (slot_i) begin
          if (we_q) state_q <= ST_ACK;
          else begin
            cnt_q   <= (sel_q == SEL_DATA) ? CNT_W'(DM_LAT - 1) : CNT_W'(CM_LAT - 1);
            state_q <= ST_LAT;
          end
        end
        ST_LAT: begin
          if (cnt_q == '0) begin
            rdata_q <= mem_rdata_i;
            state_q <= ST_ACK;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACK: if (!strobe_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = (state_q == ST_ACK);
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q == ST_WAIT);
  assign mem_we_o    = we_q;
  assign mem_sel_o   = sel_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wd_q;

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !slot_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                             && $stable(mem_sel_o));
  p_no_ack_while_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ack_o);
  p_no_data_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_sel_o != SEL_DATA);
  p_no_reserved_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_sel_o != SEL_NONE);
  p_ack_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && strobe_i |=> ack_o);
  p_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !strobe_i |=> !ack_o);
  p_write_ack_after_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && slot_i && mem_we_o |=> ack_o);
endmodule

// File: rtl/proc_reg_port.sv
module proc_reg_port
  import proc_port_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CH_W     = 5,
  parameter int ST_W     = 3,
  parameter int CTRL_DLY = 2,
  parameter int CM_LAT   = 1,
  parameter int DM_LAT   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ds_i,
  input  logic                 rw_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CTRL_W-1:0]    wdata_i,
  output logic [CTRL_W-1:0]    rdata_o,
  output logic                 ack_no,
  input  logic                 slot_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [1:0]           mem_sel_o,
  output logic [ST_W+CH_W-1:0] mem_addr_o,
  output logic [CTRL_W-1:0]    mem_wdata_o,
  input  logic [CTRL_W-1:0]    mem_rdata_i,
  output logic                 msg_en_o
);
  localparam int MA_W = ST_W + CH_W;

  logic              strobe;
  logic              ctrl_we;
  logic [CTRL_W-1:0] ctrl_q;
  logic              split;
  mem_sel_e          page_sel;
  logic [ST_W-1:0]   stream;
  logic              is_ctrl;
  logic              mem_ok;
  mem_sel_e          eff_sel;
  logic [MA_W-1:0]   maddr;
  logic              ack;
  mem_sel_e          req_sel;

  assign strobe = ~cs_ni & ds_i;

  proc_port_ctrl_reg #(.ST_W(ST_W)) i_ctrl_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_q),
    .split_o (split),
    .msg_en_o(msg_en_o),
    .sel_o   (page_sel),
    .stream_o(stream)
  );

  proc_port_decode #(.AW(AW), .CH_W(CH_W), .ST_W(ST_W)) i_decode (
    .addr_i   (addr_i),
    .rw_i     (rw_i),
    .split_i  (split),
    .sel_i    (page_sel),
    .stream_i (stream),
    .is_ctrl_o(is_ctrl),
    .mem_ok_o (mem_ok),
    .sel_o    (eff_sel),
    .maddr_o  (maddr)
  );

  proc_port_seq #(
    .DW(CTRL_W), .MA_W(MA_W), .CTRL_DLY(CTRL_DLY), .CM_LAT(CM_LAT), .DM_LAT(DM_LAT)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .rw_i       (rw_i),
    .is_ctrl_i  (is_ctrl),
    .mem_ok_i   (mem_ok),
    .sel_i      (eff_sel),
    .maddr_i    (maddr),
    .wdata_i    (wdata_i),
    .ctrl_q_i   (ctrl_q),
    .slot_i     (slot_i),
    .mem_rdata_i(mem_rdata_i),
    .ctrl_we_o  (ctrl_we),
    .ack_o      (ack),
    .rdata_o    (rdata_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_sel_o  (req_sel),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  assign ack_no    = ~ack;
  assign mem_sel_o = req_sel;

  p_split_routing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && split |-> (mem_we_o ? (req_sel == SEL_CLO) : (req_sel == SEL_DATA)));
endmodule

// File: tb/test_proc_reg_port.sv
module test_proc_reg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack_n;
  logic       slot = 1'b1;
  logic       mem_req, mem_we;
  logic [1:0] mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       msg_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  proc_reg_port i_proc_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ds_i(ds), .rw_i(rw), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_no(ack_n), .slot_i(slot),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_sel_o(mem_sel), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .msg_en_o(msg_en)
  );

  // memory model: captures each granted request
  logic [7:0] cml [256];
  logic [7:0] cmh [256];
  logic [1:0] g_sel;
  logic [7:0] g_addr, g_wd;
  logic       g_we;
  int         n_grant = 0;
  bit         dm_written = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin cml[i] <= 8'h00; cmh[i] <= 8'h00; end
    end else if (mem_req && slot) begin
      g_sel <= mem_sel; g_addr <= mem_addr; g_we <= mem_we; g_wd <= mem_wdata;
      n_grant <= n_grant + 1;
      if (mem_we) begin
        if (mem_sel == 2'b10) cml[mem_addr] <= mem_wdata;
        else if (mem_sel == 2'b11) cmh[mem_addr] <= mem_wdata;
        else dm_written <= 1;
      end
    end
  end

  function automatic logic [7:0] dm_val(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  assign mem_rdata = (g_sel == 2'b01) ? dm_val(g_addr) :
                     (g_sel == 2'b10) ? cml[g_addr] : cmh[g_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one full bus cycle; returns read data and edges to acknowledge
  task automatic access(input logic is_rd, input logic [5:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int edges);
    edges = 0;
    @(negedge clk);
    cs_n = 1'b0; ds = 1'b1; rw = is_rd; addr = a; wdata = d;
    forever begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (!ack_n || edges > 40) break;
    end
    rd = rdata;
    @(posedge clk); @(negedge clk);
    chk(ack_n == 1'b0, "R9 ack held", ack_n, 0);
    ds = 1'b0; cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ack_n == 1'b1, "R9 ack released", ack_n, 1);
  endtask

  task automatic t_reset();
    logic [7:0] rd; int e;
    chk(ack_n == 1'b1, "R1 ack idle", ack_n, 1);
    chk(mem_req == 1'b0, "R1 no request", mem_req, 0);
    chk(msg_en == 1'b0, "R1 msg_en", msg_en, 0);
    access(1, 6'h00, 0, rd, e);
    chk(rd == 8'h00, "R1 ctrl cleared", rd, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] rd; int e;
    access(0, 6'h1E, 8'h7F, rd, e);
    chk(e == 3, "R3 ctrl write ack edges", e, 3);
    access(1, 6'h01, 0, rd, e);
    chk(e == 3, "R3 ctrl read ack edges", e, 3);
    chk(rd == 8'h5F, "R2 ctrl readback spare bit zero", rd, 8'h5F);
    chk(msg_en == 1'b1, "R2 msg_en set", msg_en, 1);
    access(0, 6'h00, 8'h00, rd, e);
    chk(msg_en == 1'b0, "R2 msg_en cleared", msg_en, 0);
  endtask

  task automatic t_mem();
    logic [7:0] rd; int e;
    access(0, 6'h00, 8'h15, rd, e);           // connection-low, stream 5
    access(0, 6'h27, 8'h3C, rd, e);
    chk(e == 2, "R8 write ack edges", e, 2);
    chk(g_addr == 8'd167 && g_sel == 2'b10 && g_we, "R4 clo write addr", {g_sel, g_addr}, {2'b10, 8'd167});
    chk(g_wd == 8'h3C, "R4 write data", g_wd, 8'h3C);
    access(1, 6'h27, 0, rd, e);
    chk(e == 3, "R8 conn read ack edges", e, 3);
    chk(rd == 8'h3C, "R8 conn read data", rd, 8'h3C);
    access(0, 6'h00, 8'h1A, rd, e);           // connection-high, stream 2
    access(0, 6'h3F, 8'h47, rd, e);
    chk(g_addr == 8'd95 && g_sel == 2'b11, "R4 chi write addr", {g_sel, g_addr}, {2'b11, 8'd95});
    access(1, 6'h3F, 0, rd, e);
    chk(rd == 8'h47, "R4 chi read data", rd, 8'h47);
    access(0, 6'h00, 8'h0B, rd, e);           // data memory, stream 3
    access(1, 6'h24, 0, rd, e);
    chk(e == 5, "R8 data read ack edges", e, 5);
    chk(g_sel == 2'b01 && g_addr == 8'd100, "R4 data read addr", {g_sel, g_addr}, {2'b01, 8'd100});
    chk(rd == dm_val(8'd100), "R8 data read value", rd, dm_val(8'd100));
  endtask

  task automatic t_refused();
    logic [7:0] rd; int e, g0;
    g0 = n_grant;
    access(0, 6'h21, 8'hEE, rd, e);           // write to data memory page
    chk(n_grant == g0 && !dm_written, "R5 data write refused", n_grant - g0, 0);
    chk(e == 3, "R5 refused ack edges", e, 3);
    access(1, 6'h21, 0, rd, e);
    chk(rd == dm_val(8'd97), "R5 data memory unchanged", rd, dm_val(8'd97));
    access(0, 6'h00, 8'h04, rd, e);           // reserved select
    g0 = n_grant;
    access(1, 6'h23, 0, rd, e);
    chk(rd == 8'h00 && e == 3, "R5 reserved read", {rd, e[7:0]}, {8'h00, 8'd3});
    access(0, 6'h23, 8'h99, rd, e);
    chk(n_grant == g0, "R5 reserved no request", n_grant - g0, 0);
  endtask

  task automatic t_split();
    logic [7:0] rd; int e;
    access(0, 6'h00, 8'h99, rd, e);           // split, select chi, stream 1
    access(0, 6'h29, 8'h81, rd, e);
    chk(g_sel == 2'b10 && g_addr == 8'd41, "R6 split write to clo", {g_sel, g_addr}, {2'b10, 8'd41});
    chk(cml[41] == 8'h81, "R6 split write stored", cml[41], 8'h81);
    access(1, 6'h29, 0, rd, e);
    chk(g_sel == 2'b01 && e == 5, "R6 split read from data", {g_sel, e[7:0]}, {2'b01, 8'd5});
    chk(rd == dm_val(8'd41), "R6 split read value", rd, dm_val(8'd41));
    access(0, 6'h00, 8'h19, rd, e);           // split off
    access(1, 6'h29, 0, rd, e);
    chk(g_sel == 2'b11, "R6 split cleared uses select", g_sel, 2'b11);
  endtask

  task automatic t_slot();
    logic [7:0] rd; int e;
    access(0, 6'h00, 8'h10, rd, e);           // connection-low, stream 0
    @(negedge clk);
    slot = 1'b0;
    cs_n = 1'b0; ds = 1'b1; rw = 1'b0; addr = 6'h2C; wdata = 8'h5A;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      chk(mem_req && ack_n && mem_addr == 8'd12, "R7 wait for slot", {mem_req, ack_n}, 2'b11);
    end
    slot = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ack_n == 1'b0, "R7 ack after grant", ack_n, 0);
    chk(cml[12] == 8'h5A, "R7 write landed", cml[12], 8'h5A);
    ds = 1'b0; cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ack_n == 1'b1, "R9 release after slot", ack_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_mem();
    t_refused();
    t_split();
    t_slot();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule